// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer Controller

This block sits behind the byte engine of a two-wire serial EEPROM slave and owns the write path into the storage array. The byte engine reports bus events to it: START and STOP conditions, a strobe when a control byte selecting an array write has matched this device, and a strobe with the value of every later byte. The controller decides the acknowledge for each of these bytes. It loads the word address into its address pointer and collects the data bytes into a page buffer of `PAGE_BYTES` entries. When STOP arrives it runs a timed internal programming cycle that rewrites the whole page into a behavioural memory array.

While the programming cycle runs, the controller refuses every byte. A bus master can therefore poll with control bytes until one is acknowledged. Each bank is split into two halves, and each half has a write-protect bit. A write aimed at a protected half is refused at its first data byte and leaves the array untouched. The cycle length is the parameter `WC_CYCLES`, given in clock cycles. It must be at least `PAGE_BYTES`, because the page is copied one byte per clock at the start of the cycle.

Top module: `eeprom_page_writer`

## Requirements
- R1: A `cmd_vld` strobe while not busy is acknowledged. The next `rx_vld` byte is the word address, and it too is acknowledged. The pointer `ptr` becomes `{bank_sel, rx_byte}`, so bit 8 is the bank and bits 7:0 are the word address. Each acknowledge decision appears as `ack_vld`=1 with `ack_ok` (1 = ACK, 0 = NACK) one clock after its strobe.
- R2: Each data byte accepted after the address is acknowledged and buffered at the pointer's low 4 bits. The low 4 bits then increment. Pointer bits 8:4 (bank and page) never change while data is being taken.
- R3: Data bytes that pass the end of the 16-byte aligned page wrap to its first byte, and never spill into the next page. When more than 16 data bytes arrive, a later byte overwrites the earlier one buffered at the same position.
- R4: A STOP that follows at least one accepted data byte raises `busy` on the next clock. `busy` then stays high for exactly `WC_CYCLES` clocks. `mem_we` is asserted only while `busy` is high.
- R5: One programming cycle writes all 16 bytes of the page to the array once each, in ascending order. Positions that received no data are written back with their previous array contents.
- R6: While `busy` is high, every control byte and every other byte is answered with NACK. The pointer does not change.
- R7: The protect bit for a write is `prot[{bank, address bit 7}]`. When that bit is set, the first data byte is answered with NACK. Later bytes are also answered with NACK until the next START. Nothing is written, no cycle starts, and a new command after START is acknowledged at once.
- R8: A STOP that arrives before any data byte starts no programming cycle. The pointer keeps the address that was loaded.
- R9: After a cycle the pointer holds the last written address plus one, wrapped within the page.
- R10: Reset clears `busy`, `ack_vld`, `mem_we` and the pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | One-clock pulse: START seen on the bus |
| evt_stop | input | 1 | One-clock pulse: STOP seen on the bus |
| cmd_vld | input | 1 | One-clock pulse: control byte for an array write addressed this device |
| rx_vld | input | 1 | One-clock pulse: a byte after the control byte was received |
| rx_byte | input | 8 | Value of the received byte |
| bank_sel | input | 1 | Currently selected bank |
| prot | input | 4 | Write-protect bit per half-bank block |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| busy | output | 1 | Internal programming cycle in progress |
| ptr | output | 9 | Address pointer {bank, word address} |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 9 | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data at `mem_addr` (combinational) |

## Verification
Suppose the pointer's page bits drift or the wrap is computed across the page. Then the array image read back after the cycle shows bytes in the wrong page, or the next page is touched, and the pointer read right after the cycle disagrees. Suppose the buffer's valid mask is stale. Then refreshed positions carry old data from an earlier write instead of the array contents, which shows in the very next page comparison. An error in the protect or busy gating shows one clock after the offending strobe, as an ACK where NACK was due. It also shows as a nonzero write count on a refused transaction.

// File: rtl/epw_pkg.sv
package epw_pkg;

    localparam int BYTE_W = 8;
    localparam int PROT_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_REJECT
    } phase_e;

    // Index of the protect bit: bank in the upper bit, word-address MSB below.
    function automatic logic [1:0] block_of(input logic bank, input logic addr_msb);
        return {bank, addr_msb};
    endfunction

endpackage

// File: rtl/epw_page_buf.sv
module epw_page_buf
    import epw_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    localparam int PG_W = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PG_W-1:0]   wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr,
    input  logic [PG_W-1:0]   rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_fresh
);

    logic [BYTE_W-1:0] slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] fresh_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                fresh_q[g] <= 1'b0;
                slot_q[g]  <= '0;
            end else if (clr) begin
                fresh_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == PG_W'(g))) begin
                fresh_q[g] <= 1'b1;
                slot_q[g]  <= wr_data;
            end
        end
    end

    assign rd_data  = slot_q[rd_idx];
    assign rd_fresh = fresh_q[rd_idx];

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fresh_q == '0)); // R5

endmodule

// File: rtl/epw_ctrl.sv
module epw_ctrl
    import epw_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    localparam int PG_W = $clog2(PAGE_BYTES),
    localparam int HI_W = BYTE_W - PG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_start,
    input  logic              evt_stop,
    input  logic              cmd_vld,
    input  logic              rx_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              bank_sel,
    input  logic [PROT_W-1:0] prot,
    input  logic              busy,
    output logic              ack_vld,
    output logic              ack_ok,
    output logic [BYTE_W:0]   ptr,
    output logic              buf_we,
    output logic [PG_W-1:0]   buf_idx,
    output logic [BYTE_W-1:0] buf_data,
    output logic              buf_clr,
    output logic              go
);

    phase_e          phase_q;
    logic            bank_q;
    logic [HI_W-1:0] hi_q;
    logic [PG_W-1:0] lo_q;
    logic            has_data_q;

    logic locked, take_addr, take_data, refuse_data;

    always_comb begin
        locked      = prot[block_of(bank_q, hi_q[HI_W-1])];
        take_addr   = rx_vld && !busy && (phase_q == PH_ADDR);
        take_data   = rx_vld && !busy && (phase_q == PH_DATA) && !locked;
        refuse_data = rx_vld && !busy && (phase_q == PH_DATA) && locked;
        buf_we      = take_data;
        buf_idx     = lo_q;
        buf_data    = rx_byte;
        buf_clr     = take_addr;
        go          = evt_stop && !busy && (phase_q == PH_DATA) && has_data_q;
        ptr         = {bank_q, hi_q, lo_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            bank_q     <= 1'b0;
            hi_q       <= '0;
            lo_q       <= '0;
            has_data_q <= 1'b0;
            ack_vld    <= 1'b0;
            ack_ok     <= 1'b0;
        end else begin
            ack_vld <= cmd_vld || rx_vld;
            ack_ok  <= (cmd_vld && !busy) || take_addr || take_data;
            if (evt_start || evt_stop) begin
                phase_q    <= PH_IDLE;
                has_data_q <= 1'b0;
            end else if (cmd_vld && !busy) begin
                phase_q <= PH_ADDR;
            end else if (take_addr) begin
                phase_q      <= PH_DATA;
                bank_q       <= bank_sel;
                {hi_q, lo_q} <= rx_byte;
                has_data_q   <= 1'b0;
            end else if (refuse_data) begin
                phase_q <= PH_REJECT;
            end else if (take_data) begin
                lo_q       <= lo_q + 1'b1;
                has_data_q <= 1'b1;
            end
        end
    end

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA) && rx_vld |=> $stable({bank_q, hi_q})); // R2
    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
        busy && (cmd_vld || rx_vld) |=> ack_vld && !ack_ok); // R6
    AST_BUSY_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy && !evt_start && !evt_stop |=> $stable(ptr)); // R6
    AST_REJECT_NACK: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_REJECT) && rx_vld |=> !ack_ok); // R7

endmodule

// File: rtl/epw_prog.sv
module epw_prog
    import epw_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int WC_CYCLES  = 40,
    localparam int PG_W  = $clog2(PAGE_BYTES),
    localparam int CNT_W = $clog2(WC_CYCLES + 1),
    localparam int BASE_W = BYTE_W + 1 - PG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [BASE_W-1:0] page_base,
    output logic              busy,
    output logic [PG_W-1:0]   rd_idx,
    output logic              mem_we,
    output logic [BYTE_W:0]   mem_addr
);

    logic [CNT_W-1:0]  cnt_q;
    logic [BASE_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
        end else if (!busy) begin
            if (go) begin
                busy   <= 1'b1;
                cnt_q  <= '0;
                base_q <= page_base;
            end
        end else if (cnt_q == CNT_W'(WC_CYCLES - 1)) begin
            busy <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        rd_idx   = cnt_q[PG_W-1:0];
        mem_we   = busy && (cnt_q < CNT_W'(PAGE_BYTES));
        mem_addr = {base_q, rd_idx};
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt_q < CNT_W'(WC_CYCLES)); // R4
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        busy && (cnt_q == CNT_W'(WC_CYCLES - 1)) |=> !busy); // R4

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import epw_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int WC_CYCLES  = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_start,
    input  logic        evt_stop,
    input  logic        cmd_vld,
    input  logic        rx_vld,
    input  logic [7:0]  rx_byte,
    input  logic        bank_sel,
    input  logic [3:0]  prot,
    output logic        ack_vld,
    output logic        ack_ok,
    output logic        busy,
    output logic [8:0]  ptr,
    output logic        mem_we,
    output logic [8:0]  mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);

    localparam int PG_W   = $clog2(PAGE_BYTES);
    localparam int BASE_W = BYTE_W + 1 - PG_W;

    logic              buf_we, buf_clr, go, rd_fresh;
    logic [PG_W-1:0]   buf_idx, rd_idx;
    logic [BYTE_W-1:0] buf_data, rd_data;

    epw_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .evt_start(evt_start), .evt_stop(evt_stop),
        .cmd_vld(cmd_vld), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .bank_sel(bank_sel), .prot(prot), .busy(busy),
        .ack_vld(ack_vld), .ack_ok(ack_ok), .ptr(ptr),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
        .buf_clr(buf_clr), .go(go)
    );

    epw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst(rst), .wr_en(buf_we), .wr_idx(buf_idx),
        .wr_data(buf_data), .clr(buf_clr), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_fresh(rd_fresh)
    );

    epw_prog #(.PAGE_BYTES(PAGE_BYTES), .WC_CYCLES(WC_CYCLES)) u_prog (
        .clk(clk), .rst(rst), .go(go), .page_base(ptr[BYTE_W:PG_W]),
        .busy(busy), .rd_idx(rd_idx), .mem_we(mem_we), .mem_addr(mem_addr)
    );

    // Fresh positions take buffered data; others are refreshed from the array.
    assign mem_wdata = rd_fresh ? rd_data : mem_rdata;

    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        go |=> busy); // R4
    AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy && !buf_we); // R4
    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (rst)
        mem_we && $past(mem_we) |-> mem_addr[8:PG_W] == $past(mem_addr[8:PG_W])); // R3
    AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        mem_we && $past(mem_we) |-> mem_addr[PG_W-1:0] == $past(mem_addr[PG_W-1:0]) + 1'b1); // R5
    AST_NO_BASE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        busy && !go |=> $stable(ptr[BASE_W+PG_W-1:PG_W])); // R6

endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;

    localparam int WC = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_start = 0, evt_stop = 0, cmd_vld = 0, rx_vld = 0, bank_sel = 0;
    logic [7:0] rx_byte = '0;
    logic [3:0] prot = '0;
    logic       ack_vld, ack_ok, busy, mem_we;
    logic [8:0] ptr, mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk; // 50 MHz

    eeprom_page_writer #(.PAGE_BYTES(16), .WC_CYCLES(WC)) i_eeprom_page_writer (
        .clk(clk), .rst(rst), .evt_start(evt_start), .evt_stop(evt_stop),
        .cmd_vld(cmd_vld), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .bank_sel(bank_sel), .prot(prot), .ack_vld(ack_vld), .ack_ok(ack_ok),
        .busy(busy), .ptr(ptr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Behavioural array with combinational read.
    logic [7:0] mem [512];
    logic [7:0] exp_mem [512];
    int wr_cnt = 0;
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
    end

    int  checks = 0, errors = 0;
    bit  exp_q[$];
    int  req_q[$];
    bit  done = 0;

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: each acknowledge decision is compared with the queued expectation.
    always @(negedge clk) if (!rst && ack_vld) begin
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected ack decision: actual=%0d expected=none", ack_ok);
        end else begin
            bit e; int r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            if (ack_ok != e) begin
                errors++;
                $display("FAIL R%0d ack decision: actual=%0d expected=%0d", r, ack_ok, e);
            end
        end
    end

    task automatic send_cmd(input bit exp, input int r);
        exp_q.push_back(exp); req_q.push_back(r);
        cmd_vld = 1; @(negedge clk); cmd_vld = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp, input int r);
        exp_q.push_back(exp); req_q.push_back(r);
        rx_byte = b; rx_vld = 1; @(negedge clk); rx_vld = 0;
    endtask

    task automatic do_start();
        evt_start = 1; @(negedge clk); evt_start = 0;
    endtask

    task automatic do_stop();
        evt_stop = 1; @(negedge clk); evt_stop = 0;
    endtask

    // Counts busy clocks; optionally injects a command and a byte mid-cycle (R6).
    task automatic run_cycle(input bit inject, input int exp_len, input string req);
        int n = 0;
        logic [8:0] p0 = ptr;
        while (busy && n < 1000) begin
            n++;
            cmd_vld = 0; rx_vld = 0;
            if (inject && n == 2) begin
                exp_q.push_back(0); req_q.push_back(6); cmd_vld = 1;
            end else if (inject && n == 3) begin
                exp_q.push_back(0); req_q.push_back(6); rx_byte = 8'hEE; rx_vld = 1;
            end
            @(negedge clk);
        end
        cmd_vld = 0; rx_vld = 0;
        check(req, n, exp_len, "busy length");
        if (inject) check("R6", int'(ptr), int'(p0), "pointer after refused bytes");
    endtask

    task automatic ref_write(input logic bk, input logic [7:0] a, input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++)
            exp_mem[{bk, a[7:4], 4'(a[3:0] + i)}] = 8'(seed + i);
    endtask

    task automatic check_page(input logic bk, input logic [3:0] hi, input string req);
        int bad = 0;
        for (int i = 0; i < 16; i++)
            if (mem[{bk, hi, 4'(i)}] !== exp_mem[{bk, hi, 4'(i)}]) bad++;
        check(req, bad, 0, "mismatched bytes in page");
    endtask

    task automatic page_write(input logic bk, input logic [7:0] a, input int n, input logic [7:0] seed);
        do_start();
        send_cmd(1, 1);
        bank_sel = bk;
        send_byte(a, 1, 1);
        for (int i = 0; i < n; i++) send_byte(8'(seed + i), 1, (i >= 16) ? 3 : 2);
        ref_write(bk, a, n, seed);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int w0;
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", busy, 0, "busy in reset");
        check("R10", ack_vld, 0, "ack_vld in reset");
        check("R10", mem_we, 0, "mem_we in reset");
        check("R10", int'(ptr), 0, "pointer in reset");
        rst = 0;
        @(negedge clk);

        // R1 R2 R4 R5 R6 R9: single byte write in bank 0
        page_write(0, 8'h23, 1, 8'hA1);
        check("R1", int'(ptr), 9'h024, "pointer after one data byte");
        w0 = wr_cnt;
        do_stop();
        check("R4", busy, 1, "busy one clock after STOP");
        run_cycle(1, WC, "R4");
        check("R5", wr_cnt - w0, 16, "array writes per cycle");
        check_page(0, 4'h2, "R5");
        check("R9", int'(ptr), 9'h024, "pointer after cycle");

        // R3 R2 R9: 18 bytes into bank 1 from 0x5E wrap inside the page
        page_write(1, 8'h5E, 18, 8'hC0);
        w0 = wr_cnt;
        do_stop();
        run_cycle(0, WC, "R4");
        check("R3", wr_cnt - w0, 16, "writes stay within one page");
        check_page(1, 4'h5, "R3");
        check_page(1, 4'h6, "R3");
        check("R9", int'(ptr), 9'h150, "pointer wrapped within page");

        // R8: STOP after address only
        do_start();
        send_cmd(1, 1);
        bank_sel = 0;
        send_byte(8'h77, 1, 1);
        w0 = wr_cnt;
        do_stop();
        run_cycle(0, 0, "R8");
        check("R8", wr_cnt - w0, 0, "no array writes");
        check("R8", int'(ptr), 9'h077, "pointer loaded by address");

        // R7: block 2 (bank 1, lower half) protected
        prot = 4'b0100;
        do_start();
        send_cmd(1, 1);
        bank_sel = 1;
        send_byte(8'h10, 1, 1);
        send_byte(8'h99, 0, 7);
        send_byte(8'h98, 0, 7);
        w0 = wr_cnt;
        do_stop();
        run_cycle(0, 0, "R7");
        check("R7", wr_cnt - w0, 0, "no array writes when protected");
        check_page(1, 4'h1, "R7");
        // R7: ready at once; bank 0 upper half is unprotected
        page_write(0, 8'h90, 2, 8'h3C);
        do_stop();
        run_cycle(0, WC, "R7");
        check_page(0, 4'h9, "R7");
        check("R9", int'(ptr), 9'h092, "pointer after unprotected write");

        repeat (3) @(negedge clk);
        check("R1", exp_q.size(), 0, "outstanding ack decisions");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule